// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog peripheral with a small synchronous register port. A down-counter restarts from a programmable reload value. Each time the counter expires, it reloads and counts again. The first expiry sets a pending status bit and, if interrupts are enabled, raises an interrupt. Software is expected to service the watchdog before the next expiry. To do so it clears the pending bit and rewrites the reload value. If the counter expires a second time while the pending bit is still set, and reset escalation is enabled, the block emits a reset request pulse. It also records a sticky flag that stays set until the block itself is reset.

Every register write is refused while the block is locked, except a write to the lock register. Writing the 32-bit key 0x1ACCE551 to the lock register opens the other registers. Writing any other value to it closes them again. Reads are always permitted. Registers sit at word offsets on a 3-bit address:

| Offset | Register |
|--------|----------|
| 0 | reload |
| 1 | current count (read-only) |
| 2 | control |
| 3 | status clear |
| 4 | pending status |
| 5 | lock |

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the block is locked. Reading offset 5 returns 1 while locked and 0 while unlocked. Writing exactly 0x1ACCE551 to offset 5 unlocks the block.
- R2: Writing any value other than 0x1ACCE551 to offset 5 (for example 0xDEADDEAD or 0x1ACCE550) locks the block. While locked, writes to offsets 0, 2 and 3 leave every register unchanged.
- R3: An unlocked write to offset 0 stores the reload value, which reads back at offset 0. In the same edge it restarts the count from that value, which reads back at offset 1.
- R4: Control is at offset 2. Bit 0 enables both the counter and the interrupt, and bit 1 enables reset escalation. Offset 2 reads back only these two bits. While bit 0 is set the count drops by one per clock; while it is clear the count holds.
- R5: An expiry happens on a clock edge where bit 0 is set and the count is 0. On that edge the count reloads and bit 0 of offset 4 (pending) is set. irq_o is high exactly when pending and control bit 0 are both set. With reload value L, the first expiry happens L+1 clocks after the counter starts from L.
- R6: An expiry that finds pending already set while control bit 1 is set drives rst_req_o high for the one cycle after that edge. Pending stays set.
- R7: With control bit 1 clear, repeated expiries never assert rst_req_o or rst_seen_o.
- R8: An unlocked write of any data to offset 3 clears pending, so the next expiry counts as a first expiry again. An expiry on the same edge as the clear wins, and pending is left set.
- R9: rst_seen_o rises together with the first rst_req_o pulse and stays high until rst_ni is asserted.
- R10: Offset 4 reports pending even while control bit 0 is clear and irq_o is low.
- R11: Reset values are: control 0, pending 0, reload and count both equal to parameter RELOAD_INIT (default 0xFFFFFFFF), irq_o 0 and rst_req_o 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Warning interrupt (pending AND control bit 0) |
| rst_req_o | output | 1 | One-cycle reset request on a second-stage expiry |
| rst_seen_o | output | 1 | Sticky flag: a reset request has been issued |

## Verification
The bound checker checks the following on every cycle:
- the lock key decode;
- that locked reload writes leave the reload value unchanged;
- the immediate restart on a reload write;
- the decrement of a running count;
- that an expiry sets pending;
- that a reset request only follows an expiry with pending already set;
- that the sticky reset flag never drops.

The bench scenarios cover the end-to-end sequences that a cycle property cannot show. These are:
- the exact L+1-cycle expiry spacing;
- the two-expiry escalation;
- servicing between expiries, which turns the following expiry back into a first one;
- the disabled-escalation case;
- that pending stays readable after the interrupt is masked.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 3'd5;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic rst_en;
    logic run_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] RELOAD_INIT = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o,
  output logic [DATA_W-1:0] reload_o,
  output ctrl_t             ctrl_o,
  output logic              reload_wr_o,
  output logic              clear_wr_o
);
  logic wr_open;

  assign wr_open     = we_i && !locked_o;
  assign reload_wr_o = wr_open && (addr_i == OFS_RELOAD);
  assign clear_wr_o  = wr_open && (addr_i == OFS_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b1;
    end else if (we_i && addr_i == OFS_LOCK) begin
      locked_o <= (wdata_i != UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_o <= RELOAD_INIT;
    end else if (reload_wr_o) begin
      reload_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (wr_open && addr_i == OFS_CTRL) begin
      ctrl_o <= ctrl_t'(wdata_i[1:0]);
    end
  end
endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
  parameter int unsigned         CNT_W       = 32,
  parameter logic [CNT_W-1:0]    RELOAD_INIT = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] restart_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  // restart has priority over both decrement and expiry
  assign expire_o = run_i && !restart_i && (count_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= RELOAD_INIT;
    end else if (restart_i) begin
      count_o <= restart_val_i;
    end else if (expire_o) begin
      count_o <= reload_i;
    end else if (run_i) begin
      count_o <= count_o - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clear_i,
  input  logic rst_en_i,
  output logic pend_o,
  output logic rst_req_o,
  output logic rst_seen_o
);
  logic second_hit;

  assign second_hit = expire_i && pend_o && rst_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
    end else if (expire_i) begin
      pend_o <= 1'b1;
    end else if (clear_i) begin
      pend_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o  <= 1'b0;
      rst_seen_o <= 1'b0;
    end else begin
      rst_req_o <= second_hit;
      if (second_hit) rst_seen_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter logic [31:0] RELOAD_INIT = 32'hFFFF_FFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        rst_req_o,
  output logic        rst_seen_o
);
  logic              locked;
  logic [DATA_W-1:0] reload;
  ctrl_t             ctrl;
  logic              reload_wr;
  logic              clear_wr;
  logic [DATA_W-1:0] count;
  logic              expire;
  logic              pend;

  wdog_regfile #(.RELOAD_INIT(RELOAD_INIT)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .locked_o    (locked),
    .reload_o    (reload),
    .ctrl_o      (ctrl),
    .reload_wr_o (reload_wr),
    .clear_wr_o  (clear_wr)
  );

  wdog_downcount #(.CNT_W(DATA_W), .RELOAD_INIT(RELOAD_INIT)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (ctrl.run_en),
    .restart_i     (reload_wr),
    .restart_val_i (wdata_i),
    .reload_i      (reload),
    .count_o       (count),
    .expire_o      (expire)
  );

  wdog_escalate u_esc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expire_i   (expire),
    .clear_i    (clear_wr),
    .rst_en_i   (ctrl.rst_en),
    .pend_o     (pend),
    .rst_req_o  (rst_req_o),
    .rst_seen_o (rst_seen_o)
  );

  assign irq_o = pend && ctrl.run_en;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_RELOAD: rdata_o = reload;
      OFS_COUNT:  rdata_o = count;
      OFS_CTRL:   rdata_o = {{(DATA_W-2){1'b0}}, ctrl};
      OFS_PEND:   rdata_o = {{(DATA_W-1){1'b0}}, pend};
      OFS_LOCK:   rdata_o = {{(DATA_W-1){1'b0}}, locked};
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
  import wdog_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              locked,
  input logic [DATA_W-1:0] reload,
  input logic [DATA_W-1:0] count,
  input logic [1:0]        ctrl_bits,
  input logic              pend,
  input logic              rst_req_o,
  input logic              rst_seen_o
);
  logic run_tick;
  assign run_tick = ctrl_bits[0] && !(we_i && !locked && addr_i == OFS_RELOAD);

  AST_LOCK_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_LOCK) |=> (locked == ($past(wdata_i) != UNLOCK_KEY))); // R1
  AST_LOCKED_RELOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && we_i && addr_i == OFS_RELOAD) |=> $stable(reload)); // R2
  AST_RELOAD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked && we_i && addr_i == OFS_RELOAD) |=> (count == $past(wdata_i))); // R3
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_tick && count != '0) |=> (count == $past(count) - 1'b1)); // R4
  AST_EXPIRE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_tick && count == '0) |=> (pend && count == $past(reload))); // R5
  AST_REQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> ($past(pend) && $past(ctrl_bits[1]))); // R6
  AST_SEEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_seen_o |=> rst_seen_o); // R9
endmodule

bind wdog_two_stage wdog_two_stage_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .locked     (locked),
  .reload     (reload),
  .count      (count),
  .ctrl_bits  (ctrl),
  .pend       (pend),
  .rst_req_o  (rst_req_o),
  .rst_seen_o (rst_seen_o)
);

// File: tb/wdog_two_stage_tb_top.sv
module wdog_two_stage_tb_top;
  localparam logic [2:0]  A_RELOAD = 3'd0;
  localparam logic [2:0]  A_COUNT  = 3'd1;
  localparam logic [2:0]  A_CTRL   = 3'd2;
  localparam logic [2:0]  A_CLEAR  = 3'd3;
  localparam logic [2:0]  A_PEND   = 3'd4;
  localparam logic [2:0]  A_LOCK   = 3'd5;
  localparam logic [31:0] KEY      = 32'h1ACC_E551;

  typedef struct packed {
    logic        we;
    logic [2:0]  waddr;
    logic [31:0] wdata;
    logic [2:0]  raddr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, A_RELOAD, 32'd7,          A_RELOAD, 32'hFFFF_FFFF, 8'd2}, // R2 locked reload write
    '{1'b1, A_CTRL,   32'd3,          A_CTRL,   32'd0,         8'd2}, // R2 locked ctrl write
    '{1'b1, A_LOCK,   KEY,            A_LOCK,   32'd0,         8'd1}, // R1 unlock
    '{1'b1, A_RELOAD, 32'd7,          A_COUNT,  32'd7,         8'd3}, // R3 restart
    '{1'b0, A_RELOAD, 32'd0,          A_RELOAD, 32'd7,         8'd3}, // R3 readback
    '{1'b1, A_LOCK,   32'hDEAD_DEAD,  A_LOCK,   32'd1,         8'd2}, // R2 relock
    '{1'b1, A_RELOAD, 32'd9,          A_RELOAD, 32'd7,         8'd2}, // R2 ignored
    '{1'b1, A_LOCK,   KEY,            A_LOCK,   32'd0,         8'd1}, // R1
    '{1'b1, A_LOCK,   32'h1ACC_E550,  A_LOCK,   32'd1,         8'd2}, // R2 near-key
    '{1'b1, A_LOCK,   KEY,            A_LOCK,   32'd0,         8'd1}, // R1
    '{1'b1, A_CTRL,   32'hFFFF_FFF2,  A_CTRL,   32'd2,         8'd4}, // R4 two bits kept
    '{1'b0, A_CTRL,   32'd0,          A_COUNT,  32'd7,         8'd4}  // R4 held while stopped
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o, rst_seen_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  wdog_two_stage dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .rst_req_o(rst_req_o), .rst_seen_o(rst_seen_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic apply_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; we_i = 1'b0;
    wait_cyc(2);
    rst_ni = 1'b1;
    wait_cyc(1);
  endtask

  task automatic start_run(input logic [31:0] rl, input logic [31:0] c);
    do_write(A_LOCK, KEY);
    do_write(A_RELOAD, rl);
    do_write(A_CTRL, c);
    do_write(A_RELOAD, rl);  // count == rl now, running
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    apply_reset();
    // R11 reset state
    check("R11", {31'd0, irq_o}, 32'd0);
    check("R11", {31'd0, rst_req_o}, 32'd0);
    check("R9",  {31'd0, rst_seen_o}, 32'd0);
    rd_check("R1",  A_LOCK,   32'd1);
    rd_check("R11", A_CTRL,   32'd0);
    rd_check("R11", A_PEND,   32'd0);
    rd_check("R11", A_RELOAD, 32'hFFFF_FFFF);
    rd_check("R11", A_COUNT,  32'hFFFF_FFFF);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].we) do_write(VEC[i].waddr, VEC[i].wdata);
      else wait_cyc(1);
      rd_check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].raddr, VEC[i].exp);
    end

    // R5 R6 R9: two-stage escalation, reload 4
    apply_reset();
    start_run(32'd4, 32'd3);
    rd_check("R3", A_COUNT, 32'd4);
    wait_cyc(1);
    rd_check("R4", A_COUNT, 32'd3);
    wait_cyc(3);
    rd_check("R4", A_COUNT, 32'd0);
    check("R5", {31'd0, irq_o}, 32'd0);
    wait_cyc(1);
    check("R5", {31'd0, irq_o}, 32'd1);
    rd_check("R5", A_COUNT, 32'd4);
    rd_check("R5", A_PEND, 32'd1);
    wait_cyc(4);
    check("R6", {31'd0, rst_req_o}, 32'd0);
    wait_cyc(1);
    check("R6", {31'd0, rst_req_o}, 32'd1);
    check("R9", {31'd0, rst_seen_o}, 32'd1);
    wait_cyc(1);
    check("R6", {31'd0, rst_req_o}, 32'd0);
    rd_check("R6", A_PEND, 32'd1);
    wait_cyc(20);
    check("R9", {31'd0, rst_seen_o}, 32'd1);
    apply_reset();
    check("R9", {31'd0, rst_seen_o}, 32'd0);

    // R8: clearing between expiries makes the next one a first expiry
    start_run(32'd4, 32'd3);
    wait_cyc(5);
    check("R8", {31'd0, irq_o}, 32'd1);
    do_write(A_CLEAR, 32'hABCD_0000);
    rd_check("R8", A_PEND, 32'd0);
    check("R8", {31'd0, irq_o}, 32'd0);
    for (int k = 0; k < 20 && !irq_o; k++) wait_cyc(1);
    check("R8", {31'd0, irq_o}, 32'd1);
    check("R8", {31'd0, rst_seen_o}, 32'd0);

    // R7: escalation disabled
    apply_reset();
    start_run(32'd2, 32'd1);
    wait_cyc(12);
    check("R7", {31'd0, rst_seen_o}, 32'd0);
    check("R7", {31'd0, rst_req_o}, 32'd0);
    check("R7", {31'd0, irq_o}, 32'd1);

    // R10: pending visible with interrupt masked; count holds
    do_write(A_CTRL, 32'd0);
    check("R10", {31'd0, irq_o}, 32'd0);
    rd_check("R10", A_PEND, 32'd1);
    begin
      logic [31:0] snap;
      addr_i = A_COUNT; #1; snap = rdata_o;
      wait_cyc(3);
      rd_check("R4", A_COUNT, snap);
    end

    // R2: locked clear write ignored
    do_write(A_LOCK, 32'd0);
    do_write(A_CLEAR, 32'd1);
    rd_check("R2", A_PEND, 32'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule